// File: doc/BRIEF.md
# Frequent-Pattern Line Compressor

This block shrinks one 64-byte cache line into a packed bitstream. The line arrives as sixteen 32-bit words with a single-cycle valid strobe. Every word is sorted on its own into one of a handful of common value shapes: zero, a small signed number, a halfword with an empty low half, two byte-sized signed halves, or one byte repeated. The word is then written as a 3-bit shape code followed by only the bits that shape needs. Words that fit no shape are written as the code followed by all 32 bits.

The fields are concatenated from word 0 upward, most significant bit first. The length is rounded up to whole 64-bit segments. If the rounded size would be eight segments or more, nothing is gained, so the line leaves unchanged with a flag saying it was not compressed. A new line may be accepted every cycle. The result appears a fixed three cycles later.

Top module: `fpc_line_compressor`

## Requirements
- R1: Each word's field depends only on that word. Decoding the emitted stream (codes below, fields in order, or the raw layout when not compressed) rebuilds the input line exactly.
- R2: A word equal to zero is coded 0 and carries no payload bits.
- R3: The shape codes and their payloads are fixed. Code 1 is a value sign-extended from 4 bits, with the low 4 bits kept. Code 2 is a value sign-extended from 8 bits, with the low 8 kept. Code 3 is a value sign-extended from 16 bits, with the low 16 kept. Code 4 has a zero low halfword, and the upper 16 bits are kept. Code 5 has each halfword sign-extended from its low byte, and bits 23:16 then 7:0 are kept. Code 6 has all four bytes equal, and one byte is kept. Code 7 is raw, with all 32 bits kept.
- R4: When several shapes match, the one with the fewest payload bits wins, and a tie goes to the lower code. Example: 0xFFFFFFFF is coded 1, 0xFFFF0000 is coded 4, and 0x00000010 is coded 2.
- R5: Word 0's field starts at `out_stream[511]`. Each field is the code (MSB first) followed by its payload (MSB first). All bits after the last field are zero.
- R6: When compressed, `out_len_bits` is the field total rounded up to a multiple of 64.
- R7: If the rounded total is 512 or more, `out_compressed` is 0 and `out_len_bits` is 512. In that case `out_stream[511-32*i -: 32]` holds input word i, and `in_line[32*i +: 32]` is word i.
- R8: `out_valid` rises exactly three clock cycles after a cycle with `in_valid` high. Back-to-back lines are accepted every cycle.
- R9: While reset is asserted and just after it, `out_valid`, `out_compressed`, `out_len_bits` and `out_stream` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Line present on `in_line` this cycle |
| in_line | input | 512 | Sixteen words, word i in bits 32*i+31:32*i |
| out_valid | output | 1 | Result present this cycle |
| out_stream | output | 512 | Packed fields or the unchanged line |
| out_len_bits | output | 10 | Rounded stream length in bits |
| out_compressed | output | 1 | 1 when the line shrank below eight segments |

## Verification
A wrong shape choice or payload slice in one word shifts every later field. The damage therefore shows in the stream, and usually in the length, on the very output cycle of that line, three cycles after input. An error in the running offset or in the rounding shows as a length that is not segment-aligned, or as a flag that disagrees with the length, on the same cycle. A broken pipeline stage shows as a valid pulse one cycle off, or as data from a neighbouring line. Round-trip decoding of every output catches payload errors that still happen to produce the right length.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned CODE_BITS = 3;
  localparam int unsigned FIELD_MAX = WORD_BITS + CODE_BITS;
  localparam int unsigned SIZE_W    = 6;

  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [SIZE_W-1:0]    size_t;

  // Shape codes; numeric values are the emitted prefix.
  typedef enum logic [2:0] {
    PAT_ZERO        = 3'd0,
    PAT_SEXT4       = 3'd1,
    PAT_SEXT8       = 3'd2,
    PAT_SEXT16      = 3'd3,
    PAT_HIGH_HALF   = 3'd4,
    PAT_TWIN_BYTE   = 3'd5,
    PAT_REPEAT_BYTE = 3'd6,
    PAT_RAW         = 3'd7
  } pat_e;

  // Number of payload bits each shape keeps.
  function automatic size_t payload_width(pat_e p);
    size_t w;
    unique case (p)
      PAT_ZERO:        w = size_t'(0);
      PAT_SEXT4:       w = size_t'(4);
      PAT_SEXT8:       w = size_t'(8);
      PAT_SEXT16:      w = size_t'(16);
      PAT_HIGH_HALF:   w = size_t'(16);
      PAT_TWIN_BYTE:   w = size_t'(16);
      PAT_REPEAT_BYTE: w = size_t'(8);
      default:         w = size_t'(32);
    endcase
    return w;
  endfunction

  // True when bits keep-1 and above all carry the same value.
  function automatic logic fits_signed(word_t w, int unsigned keep);
    logic ok;
    ok = 1'b1;
    for (int unsigned b = keep; b < WORD_BITS; b++) begin
      if (w[b] != w[keep-1]) ok = 1'b0;
    end
    return ok;
  endfunction

  // Payload bits of a word under a shape, right aligned.
  function automatic word_t payload_extract(pat_e p, word_t w);
    word_t r;
    unique case (p)
      PAT_ZERO:        r = '0;
      PAT_SEXT4:       r = {28'h0, w[3:0]};
      PAT_SEXT8:       r = {24'h0, w[7:0]};
      PAT_SEXT16:      r = {16'h0, w[15:0]};
      PAT_HIGH_HALF:   r = {16'h0, w[31:16]};
      PAT_TWIN_BYTE:   r = {16'h0, w[23:16], w[7:0]};
      PAT_REPEAT_BYTE: r = {24'h0, w[7:0]};
      default:         r = w;
    endcase
    return r;
  endfunction

  // Round a bit count up to a whole number of segments.
  function automatic int unsigned round_up_bits(int unsigned bits, int unsigned seg);
    return ((bits + seg - 1) / seg) * seg;
  endfunction

endpackage

// File: rtl/fpc_word_classifier.sv
module fpc_word_classifier
  import fpc_pkg::*;
(
  input  word_t word_i,
  output pat_e  code_o,
  output word_t payload_o,
  output size_t field_bits_o
);

  logic hit_zero, hit_s4, hit_s8, hit_s16;
  logic hit_high, hit_twin, hit_rep;

  always_comb begin
    hit_zero = (word_i == '0);
    hit_s4   = fits_signed(word_i, 4);
    hit_s8   = fits_signed(word_i, 8);
    hit_s16  = fits_signed(word_i, 16);
    hit_high = (word_i[15:0] == 16'h0);
    hit_twin = (word_i[31:24] == {8{word_i[23]}}) && (word_i[15:8] == {8{word_i[7]}});
    hit_rep  = (word_i == {4{word_i[7:0]}});
  end

  // Ordered by payload size, lower code first on a tie.
  always_comb begin
    if (hit_zero)      code_o = PAT_ZERO;
    else if (hit_s4)   code_o = PAT_SEXT4;
    else if (hit_s8)   code_o = PAT_SEXT8;
    else if (hit_rep)  code_o = PAT_REPEAT_BYTE;
    else if (hit_s16)  code_o = PAT_SEXT16;
    else if (hit_high) code_o = PAT_HIGH_HALF;
    else if (hit_twin) code_o = PAT_TWIN_BYTE;
    else               code_o = PAT_RAW;
  end

  assign payload_o    = payload_extract(code_o, word_i);
  assign field_bits_o = size_t'(CODE_BITS) + payload_width(code_o);

endmodule

// File: rtl/fpc_offset_scan.sv
module fpc_offset_scan
  import fpc_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned OFF_W     = 10
) (
  input  size_t [NUM_WORDS-1:0]            field_bits_i,
  output logic  [NUM_WORDS-1:0][OFF_W-1:0] offset_o,
  output logic  [OFF_W-1:0]                total_o
);

  logic [OFF_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < int'(NUM_WORDS); i++) begin
      offset_o[i] = acc;
      acc = acc + OFF_W'(field_bits_i[i]);
    end
    total_o = acc;
  end

endmodule

// File: rtl/fpc_stream_packer.sv
module fpc_stream_packer
  import fpc_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 16,
  parameter int unsigned STREAM_BITS = 512,
  parameter int unsigned OFF_W       = 10
) (
  input  pat_e  [NUM_WORDS-1:0]            code_i,
  input  word_t [NUM_WORDS-1:0]            payload_i,
  input  size_t [NUM_WORDS-1:0]            field_bits_i,
  input  logic  [NUM_WORDS-1:0][OFF_W-1:0] offset_i,
  output logic  [STREAM_BITS-1:0]          stream_o
);

  localparam int unsigned PAD = STREAM_BITS - FIELD_MAX;

  logic [NUM_WORDS-1:0][STREAM_BITS-1:0] placed;

  for (genvar g = 0; g < int'(NUM_WORDS); g++) begin : g_place
    size_t               pay_w;
    word_t               pay_left;
    logic [FIELD_MAX-1:0] left_field;
    assign pay_w      = field_bits_i[g] - size_t'(CODE_BITS);
    assign pay_left   = payload_i[g] << (size_t'(WORD_BITS) - pay_w);
    assign left_field = {code_i[g], pay_left};
    assign placed[g]  = {left_field, {PAD{1'b0}}} >> offset_i[g];
  end

  always_comb begin
    stream_o = '0;
    for (int i = 0; i < int'(NUM_WORDS); i++) begin
      stream_o = stream_o | placed[i];
    end
  end

endmodule

// File: rtl/fpc_line_compressor.sv
module fpc_line_compressor
  import fpc_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned SEG_BITS  = 64,
  localparam int unsigned LINE_BITS = NUM_WORDS * WORD_BITS,
  localparam int unsigned LEN_W     = $clog2(LINE_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [LINE_BITS-1:0] in_line,
  output logic                 out_valid,
  output logic [LINE_BITS-1:0] out_stream,
  output logic [LEN_W-1:0]     out_len_bits,
  output logic                 out_compressed
);

  localparam int unsigned OFF_W = $clog2(NUM_WORDS * FIELD_MAX + 1);
  localparam int unsigned RND_W = OFF_W + 1;

  // ---------------- classify (combinational from input) ----------------
  pat_e  [NUM_WORDS-1:0] c_code;
  word_t [NUM_WORDS-1:0] c_payload;
  size_t [NUM_WORDS-1:0] c_fbits;

  for (genvar g = 0; g < int'(NUM_WORDS); g++) begin : g_cls
    fpc_word_classifier u_cls (
      .word_i      (in_line[g*WORD_BITS +: WORD_BITS]),
      .code_o      (c_code[g]),
      .payload_o   (c_payload[g]),
      .field_bits_o(c_fbits[g])
    );
  end

  // ---------------- stage 1 ----------------
  logic                  s1_valid;
  logic [LINE_BITS-1:0]  s1_line;
  pat_e  [NUM_WORDS-1:0] s1_code;
  word_t [NUM_WORDS-1:0] s1_payload;
  size_t [NUM_WORDS-1:0] s1_fbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_line    <= '0;
      s1_code    <= '0;
      s1_payload <= '0;
      s1_fbits   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_line    <= in_line;
        s1_code    <= c_code;
        s1_payload <= c_payload;
        s1_fbits   <= c_fbits;
      end
    end
  end

  // ---------------- offsets ----------------
  logic [NUM_WORDS-1:0][OFF_W-1:0] sc_off;
  logic [OFF_W-1:0]                sc_total;

  fpc_offset_scan #(
    .NUM_WORDS(NUM_WORDS),
    .OFF_W    (OFF_W)
  ) u_scan (
    .field_bits_i(s1_fbits),
    .offset_o    (sc_off),
    .total_o     (sc_total)
  );

  // ---------------- stage 2 ----------------
  logic                            s2_valid;
  logic [LINE_BITS-1:0]            s2_line;
  pat_e  [NUM_WORDS-1:0]           s2_code;
  word_t [NUM_WORDS-1:0]           s2_payload;
  size_t [NUM_WORDS-1:0]           s2_fbits;
  logic [NUM_WORDS-1:0][OFF_W-1:0] s2_off;
  logic [OFF_W-1:0]                s2_total_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid      <= 1'b0;
      s2_line       <= '0;
      s2_code       <= '0;
      s2_payload    <= '0;
      s2_fbits      <= '0;
      s2_off        <= '0;
      s2_total_bits <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_line       <= s1_line;
        s2_code       <= s1_code;
        s2_payload    <= s1_payload;
        s2_fbits      <= s1_fbits;
        s2_off        <= sc_off;
        s2_total_bits <= sc_total;
      end
    end
  end

  // ---------------- pack, round, choose ----------------
  logic [LINE_BITS-1:0] pk_stream;
  logic [LINE_BITS-1:0] raw_stream;
  logic [RND_W-1:0]     rounded_bits;
  logic                 line_fits;

  fpc_stream_packer #(
    .NUM_WORDS  (NUM_WORDS),
    .STREAM_BITS(LINE_BITS),
    .OFF_W      (OFF_W)
  ) u_pack (
    .code_i      (s2_code),
    .payload_i   (s2_payload),
    .field_bits_i(s2_fbits),
    .offset_i    (s2_off),
    .stream_o    (pk_stream)
  );

  // Unchanged line laid out word 0 first from the top.
  for (genvar g = 0; g < int'(NUM_WORDS); g++) begin : g_raw
    assign raw_stream[LINE_BITS-1-g*WORD_BITS -: WORD_BITS] = s2_line[g*WORD_BITS +: WORD_BITS];
  end

  assign rounded_bits = RND_W'(round_up_bits(int'(s2_total_bits), SEG_BITS));
  assign line_fits    = (rounded_bits < RND_W'(LINE_BITS));

  // ---------------- stage 3 (outputs) ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_stream     <= '0;
      out_len_bits   <= '0;
      out_compressed <= 1'b0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) begin
        out_compressed <= line_fits;
        out_stream     <= line_fits ? pk_stream : raw_stream;
        out_len_bits   <= line_fits ? LEN_W'(rounded_bits) : LEN_W'(LINE_BITS);
      end
    end
  end

endmodule

// File: rtl/fpc_line_compressor_chk.sv
module fpc_line_compressor_chk #(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned LINE_BITS = 512,
  parameter int unsigned LEN_W     = 10,
  parameter int unsigned OFF_W     = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [LINE_BITS-1:0] out_stream,
  input logic [LEN_W-1:0]     out_len_bits,
  input logic                 out_compressed,
  input logic                 s2_valid,
  input logic [OFF_W-1:0]     s2_total_bits
);

  logic       h1, h2, h3;
  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= 1'b0; h2 <= 1'b0; h3 <= 1'b0; seen <= '0;
    end else begin
      h1 <= in_valid; h2 <= h1; h3 <= h2;
      if (seen != 2'd3) seen <= seen + 2'd1;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (out_valid == h3));                                   // R8
  AST_LEN_SEGMENT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len_bits[5:0] == 6'd0 && out_len_bits != '0));        // R6
  AST_FLAG_AGREES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_compressed == (out_len_bits < LEN_W'(LINE_BITS))));   // R7
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_compressed) |->
      ((out_stream & ({LINE_BITS{1'b1}} >> out_len_bits)) == '0));            // R5
  AST_TOTAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> (s2_total_bits >= OFF_W'(3*NUM_WORDS) &&
                  s2_total_bits <= OFF_W'(35*NUM_WORDS)));                    // R4

endmodule

bind fpc_line_compressor fpc_line_compressor_chk #(
  .NUM_WORDS(NUM_WORDS),
  .LINE_BITS(LINE_BITS),
  .LEN_W    (LEN_W),
  .OFF_W    (OFF_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .out_valid     (out_valid),
  .out_stream    (out_stream),
  .out_len_bits  (out_len_bits),
  .out_compressed(out_compressed),
  .s2_valid      (s2_valid),
  .s2_total_bits (s2_total_bits)
);

// File: tb/fpc_line_compressor_bench.sv
module fpc_line_compressor_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] in_line = '0;
  logic         out_valid;
  logic [511:0] out_stream;
  logic [9:0]   out_len_bits;
  logic         out_compressed;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;  // 50 MHz

  fpc_line_compressor u_fpc_line_compressor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line),
    .out_valid(out_valid), .out_stream(out_stream),
    .out_len_bits(out_len_bits), .out_compressed(out_compressed)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic void ref_pick(input logic [31:0] w, output int code,
                                   output int nb, output logic [31:0] pl);
    int sv = $signed(w);
    int hi = $signed(w[31:16]);
    int lo = $signed(w[15:0]);
    if (w == 0)                                  begin code = 0; nb = 0;  pl = 0; end
    else if (sv >= -8 && sv <= 7)                begin code = 1; nb = 4;  pl = w; end
    else if (sv >= -128 && sv <= 127)            begin code = 2; nb = 8;  pl = w; end
    else if (w[31:24] == w[7:0] && w[23:16] == w[7:0] && w[15:8] == w[7:0])
                                                 begin code = 6; nb = 8;  pl = w; end
    else if (sv >= -32768 && sv <= 32767)        begin code = 3; nb = 16; pl = w; end
    else if (w[15:0] == 0)                       begin code = 4; nb = 16; pl = w >> 16; end
    else if (hi >= -128 && hi <= 127 && lo >= -128 && lo <= 127)
                                                 begin code = 5; nb = 16; pl = {w[23:16], w[7:0]}; end
    else                                         begin code = 7; nb = 32; pl = w; end
  endfunction

  function automatic void ref_encode(input logic [511:0] line, output logic [511:0] st,
                                     output int len, output bit comp);
    logic [511:0] s = '0;
    int cur = 0;
    for (int i = 0; i < 16; i++) begin
      int code; int nb; logic [31:0] pl;
      ref_pick(line[32*i +: 32], code, nb, pl);
      for (int b = 2; b >= 0; b--) begin
        if (cur < 512) s[511-cur] = code[b];
        cur++;
      end
      for (int b = nb - 1; b >= 0; b--) begin
        if (cur < 512) s[511-cur] = pl[b];
        cur++;
      end
    end
    if ((cur + 63) / 64 < 8) begin
      st = s; len = ((cur + 63) / 64) * 64; comp = 1;
    end else begin
      for (int i = 0; i < 16; i++) s[511-32*i -: 32] = line[32*i +: 32];
      st = s; len = 512; comp = 0;
    end
  endfunction

  function automatic logic [511:0] ref_decode(input logic [511:0] st, input bit comp);
    logic [511:0] line = '0;
    int cur = 0;
    if (!comp) begin
      for (int i = 0; i < 16; i++) line[32*i +: 32] = st[511-32*i -: 32];
      return line;
    end
    for (int i = 0; i < 16; i++) begin
      int code = 0; int nb; logic [31:0] p = 0; logic [31:0] w;
      for (int b = 0; b < 3; b++) begin code = code * 2 + int'(st[511-cur]); cur++; end
      case (code)
        0: nb = 0; 1: nb = 4; 2: nb = 8; 6: nb = 8; 7: nb = 32; default: nb = 16;
      endcase
      for (int b = 0; b < nb; b++) begin p = {p[30:0], st[511-cur]}; cur++; end
      case (code)
        0: w = 0;
        1: w = {{28{p[3]}}, p[3:0]};
        2: w = {{24{p[7]}}, p[7:0]};
        3: w = {{16{p[15]}}, p[15:0]};
        4: w = {p[15:0], 16'h0};
        5: w = {{8{p[15]}}, p[15:8], {8{p[7]}}, p[7:0]};
        6: w = {4{p[7:0]}};
        default: w = p;
      endcase
      line[32*i +: 32] = w;
    end
    return line;
  endfunction

  // ---------------- expected pipeline and per-cycle compare ----------------
  bit           pv[3];
  logic [511:0] pl_line[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin pv[k] = 0; pl_line[k] = '0; end
    end else begin
      pv[2] = pv[1]; pl_line[2] = pl_line[1];
      pv[1] = pv[0]; pl_line[1] = pl_line[0];
      pv[0] = in_valid; pl_line[0] = in_line;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == pv[2], "R8", "out_valid", 512'(out_valid), 512'(pv[2]));
      if (pv[2] && out_valid) begin
        logic [511:0] es; int el; bit ec;
        ref_encode(pl_line[2], es, el, ec);
        check(out_stream == es, "R5", "stream", out_stream, es);
        check(int'(out_len_bits) == el, "R6", "length", 512'(out_len_bits), 512'(el));
        check(out_compressed == ec, "R7", "compressed flag", 512'(out_compressed), 512'(ec));
        check(ref_decode(out_stream, out_compressed) == pl_line[2], "R1", "round trip",
              ref_decode(out_stream, out_compressed), pl_line[2]);
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] gen_word();
    logic [31:0] r = $urandom;
    case ($urandom_range(0, 8))
      0: return 0;
      1: return {{28{r[3]}}, r[3:0]};
      2: return {{24{r[7]}}, r[7:0]};
      3: return {{16{r[15]}}, r[15:0]};
      4: return {r[15:0], 16'h0};
      5: return {{8{r[15]}}, r[15:8], {8{r[7]}}, r[7:0]};
      6: return {4{r[7:0]}};
      default: return r;
    endcase
  endfunction

  task automatic send_and_wait(input logic [511:0] line);
    @(negedge clk); in_valid = 1'b1; in_line = line;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic directed(input logic [31:0] w, input int exp_code, input int exp_len,
                          input string req);
    send_and_wait({16{w}});
    check(int'(out_stream[511:509]) == exp_code, req, "prefix of word 0",
          512'(out_stream[511:509]), 512'(exp_code));
    check(int'(out_len_bits) == exp_len, req, "directed length",
          512'(out_len_bits), 512'(exp_len));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_compressed == 0 && out_len_bits == 0 && out_stream == '0,
          "R9", "outputs in reset", {out_stream[511:2], out_valid, out_compressed}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_stream == '0, "R9", "outputs after reset",
          512'(out_valid), '0);

    directed(32'h0000_0000, 0, 64,  "R2");
    directed(32'hFFFF_FFFA, 1, 128, "R3");
    directed(32'hFFFF_FF85, 2, 192, "R3");
    directed(32'h0000_1234, 3, 320, "R3");
    directed(32'hABCD_0000, 4, 320, "R3");
    directed(32'hFF80_0012, 5, 320, "R3");
    directed(32'h5A5A_5A5A, 6, 192, "R3");
    directed(32'hFFFF_FFFF, 1, 128, "R4");
    directed(32'hFFFF_0000, 4, 320, "R4");
    directed(32'h0000_0010, 2, 192, "R4");
    directed(32'h1234_5678, 3'b000 + 0, 512, "R7");  // raw line passes through: top word's bits
    check(out_compressed == 0, "R7", "raw line flag", 512'(out_compressed), '0);

    // Packing order: word0 = 5 (code 1, 0101), word1 = 0 (code 0)
    begin
      logic [511:0] l = '0;
      l[31:0] = 32'h5;
      send_and_wait(l);
      check(out_stream[511:502] == 10'b001_0101_000, "R5", "field order",
            512'(out_stream[511:502]), 512'(10'b0010101000));
      check(out_len_bits == 10'd64, "R6", "52 bits rounds to 64", 512'(out_len_bits), 512'(64));
    end

    // 9 raw + 7 sign-extended-16 words: 315 + 133 = 448 bits
    begin
      logic [511:0] l;
      for (int i = 0; i < 16; i++) l[32*i +: 32] = (i < 9) ? 32'h1234_5678 : 32'h0000_4321;
      send_and_wait(l);
      check(out_len_bits == 10'd448 && out_compressed, "R6", "exactly seven segments",
            512'(out_len_bits), 512'(448));
      for (int i = 0; i < 16; i++) l[32*i +: 32] = (i < 10) ? 32'h1234_5678 : 32'h0000_4321;
      send_and_wait(l);
      check(out_len_bits == 10'd512 && !out_compressed, "R7", "464 bits is incompressible",
            512'(out_len_bits), 512'(512));
      check(out_stream[511:480] == 32'h1234_5678, "R7", "unchanged word 0",
            512'(out_stream[511:480]), 512'(32'h1234_5678));
    end

    // Random lines, back to back and with gaps
    for (int n = 0; n < 400; n++) begin
      logic [511:0] l;
      for (int i = 0; i < 16; i++) l[32*i +: 32] = gen_word();
      @(negedge clk); in_valid = 1'b1; in_line = l;
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule